// File: doc/BRIEF.md
# Serial Command Frame Transmitter

This block is the sending half of a master on a two-wire serial link: one clock line generated by the master and one bidirectional data line. A client hands it a single request (an addressed read, an addressed write, a data poll or a terminate) along with a 2-bit slave id, a 21-bit address, a transfer size and up to four bytes of write data. The block builds the command frame, appends a 4-bit check code, and shifts the frame out most significant bit first. It produces one link clock period per bit.

The data line is active low, so every logical bit is driven inverted. Each frame opens with a start bit whose logical value is 1, which is therefore driven low. The transfer size is not a field of its own. It is folded into the lowest address bits plus one trailing size bit. The check code is a serial x^4+x+1 remainder with a zero seed. It covers the start bit as well as every payload bit. Receiving the slave's answer, retries and link reset belong to other blocks. This block releases the data line as soon as the last check bit has been clocked out and pulses a done flag.

The link clock idles high. For each bit, the clock is held low for `HALF_PERIOD` system clocks and then high for `HALF_PERIOD` system clocks. The data line changes only at the falling edge, so it is steady whenever the slave samples it on the rising edge.

Top module: `cmd_frame_tx`

## Requirements
- R1: Out of reset and whenever idle: `req_ready`=1, `link_oe`=0, `link_clk`=1, `link_data`=1 and `tx_done`=0.
- R2: Every frame starts with a start bit of logical 1, driven as 0 on `link_data`. Every later bit is driven as the inverse of its logical value.
- R3: A read (`req_kind`=2'b00) or write (`req_kind`=2'b01) frame carries, after the start bit and in this order: slave id (2 bits, MSB first), opcode 3'b100, a direction bit (1 = read, 0 = write), the 21-bit address MSB first, and one size bit.
- R4: Size folding uses `req_size`. With 2'b00 (1 byte), the address is unchanged and the size bit is 0. With 2'b01 (2 bytes), address bit 0 is sent as 0 and the size bit is 1. With 2'b10 or 2'b11 (4 bytes), address bits [1:0] are sent as 2'b01 and the size bit is 1.
- R5: A write frame appends 1, 2 or 4 data bytes after the size bit. Byte 0 (`req_wdata[7:0]`) goes first, then byte 1 (`[15:8]`), and so on, each byte MSB first. A read frame carries no data bytes.
- R6: A data-poll frame (`req_kind`=2'b10) is the slave id (2 bits) followed by opcode 3'b010.
- R7: A terminate frame (`req_kind`=2'b11) is the slave id (2 bits) followed by the 6-bit opcode 6'h3F.
- R8: Every frame ends with 4 check bits, MSB first. They are the remainder of the start bit and all payload bits, augmented by four zeros, divided by x^4+x+1 (binary 10011).
- R9: For each bit, `link_clk` is low for `HALF_PERIOD` cycles and then high for `HALF_PERIOD` cycles. `link_data` changes only on the cycle in which `link_clk` falls, or when the line is taken or released. A frame of N bits therefore takes N*2*`HALF_PERIOD` cycles from acceptance to `tx_done`.
- R10: A request is taken on a cycle with `req_valid` and `req_ready` both high. `req_ready` then stays low until the frame is complete, and any request inputs presented meanwhile have no effect on the frame.
- R11: `tx_done` is a one-cycle pulse at the end of the high phase of the last check bit. In that same cycle `req_ready` returns to 1 and `link_oe` returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and can take a request |
| req_kind | input | 2 | 00 read, 01 write, 10 data poll, 11 terminate |
| req_slave | input | 2 | Target slave id |
| req_addr | input | 21 | Byte address for read and write |
| req_size | input | 2 | 00 one byte, 01 two bytes, 1x four bytes |
| req_wdata | input | 32 | Write bytes, byte 0 in bits [7:0] |
| link_clk | output | 1 | Generated link clock, idles high |
| link_data | output | 1 | Active-low serial data towards the slave |
| link_oe | output | 1 | High while the master drives the data line |
| tx_done | output | 1 | One-cycle pulse when the frame is complete |

## Verification
The assertions assume that `HALF_PERIOD` is at least 1. They also assume that `req_valid` may be held or changed freely while the block is busy, because the handshake only looks at it when `req_ready` is high. The stimulus drives every request field at the falling system clock edge. On the acceptance cycle it holds the fields stable. During disturbance runs it deliberately keeps `req_valid` high with altered fields while the block is busy. It always drops `req_valid` well before the frame ends, so no unintended second request is taken.

// File: rtl/cftx_pkg.sv
package cftx_pkg;

  localparam int SLV_W   = 2;
  localparam int ADDR_W  = 21;
  localparam int DATA_W  = 32;
  localparam int BYTES_MAX = DATA_W / 8;
  localparam int CRC_W   = 4;
  // start + id + opcode + dir + address + size bit + data
  localparam int BODY_MAX = 1 + SLV_W + 3 + 1 + ADDR_W + 1 + DATA_W;
  localparam int FRAME_W = 64;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    CMD_READ  = 2'b00,
    CMD_WRITE = 2'b01,
    CMD_POLL  = 2'b10,
    CMD_TERM  = 2'b11
  } cmd_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_PAY  = 2'b01,
    ST_CRC  = 2'b10
  } tx_state_e;

  localparam logic [2:0]       OPC_ABS  = 3'b100;
  localparam logic [2:0]       OPC_POLL = 3'b010;
  localparam logic [5:0]       OPC_TERM = 6'h3F;
  localparam logic [CRC_W-1:0] CRC_TAPS = 4'b0011;

  // one serial step of the x^4+x+1 remainder
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] cur,
                                                input logic din);
    logic fb;
    fb = cur[CRC_W-1] ^ din;
    return {cur[CRC_W-2:0], 1'b0} ^ (fb ? CRC_TAPS : '0);
  endfunction

  function automatic int size_bytes(input logic [1:0] sz);
    case (sz)
      2'b00:   return 1;
      2'b01:   return 2;
      default: return 4;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] fold_addr(input logic [ADDR_W-1:0] a,
                                                  input logic [1:0] sz);
    logic [ADDR_W-1:0] r;
    r = a;
    case (sz)
      2'b00:   r = a;
      2'b01:   r[0] = 1'b0;
      default: r[1:0] = 2'b01;
    endcase
    return r;
  endfunction

  function automatic logic size_flag(input logic [1:0] sz);
    return sz != 2'b00;
  endfunction

  // append w low bits of val to the right of acc
  function automatic logic [FRAME_W-1:0] push_bits(input logic [FRAME_W-1:0] acc,
                                                   input logic [FRAME_W-1:0] val,
                                                   input int w);
    logic [FRAME_W-1:0] mask;
    mask = (FRAME_W'(1) << w) - FRAME_W'(1);
    return (acc << w) | (val & mask);
  endfunction

endpackage

// File: rtl/cftx_frame_asm.sv
module cftx_frame_asm
  import cftx_pkg::*;
(
  input  cmd_kind_e          kind,
  input  logic [SLV_W-1:0]   slave,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [1:0]         size,
  input  logic [DATA_W-1:0]  wdata,
  output logic [FRAME_W-1:0] frame,   // start bit at the MSB
  output logic [CNT_W-1:0]   nbits    // start + payload, no check bits
);

  logic [FRAME_W-1:0] acc;
  int                 n;
  int                 nbytes;

  always_comb begin
    acc    = '0;
    n      = 0;
    nbytes = size_bytes(size);
    acc = push_bits(acc, FRAME_W'(1), 1);                 n = n + 1;
    acc = push_bits(acc, FRAME_W'(slave), SLV_W);         n = n + SLV_W;
    case (kind)
      CMD_READ, CMD_WRITE: begin
        acc = push_bits(acc, FRAME_W'(OPC_ABS), 3);       n = n + 3;
        acc = push_bits(acc, FRAME_W'(kind == CMD_READ), 1); n = n + 1;
        acc = push_bits(acc, FRAME_W'(fold_addr(addr, size)), ADDR_W);
        n = n + ADDR_W;
        acc = push_bits(acc, FRAME_W'(size_flag(size)), 1); n = n + 1;
        if (kind == CMD_WRITE) begin
          for (int i = 0; i < BYTES_MAX; i++) begin
            if (i < nbytes) begin
              acc = push_bits(acc, FRAME_W'(wdata[8*i +: 8]), 8);
              n = n + 8;
            end
          end
        end
      end
      CMD_POLL: begin
        acc = push_bits(acc, FRAME_W'(OPC_POLL), 3);      n = n + 3;
      end
      default: begin
        acc = push_bits(acc, FRAME_W'(OPC_TERM), 6);      n = n + 6;
      end
    endcase
    frame = acc << (FRAME_W - n);
    nbits = CNT_W'(n);
  end

endmodule

// File: rtl/cftx_phase_timer.sv
module cftx_phase_timer #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic rise_evt,
  output logic fall_evt
);

  localparam int PER = 2 * HALF;
  localparam int TW  = (PER > 1) ? $clog2(PER) : 1;

  logic [TW-1:0] tmr;

  assign rise_evt = run && (tmr == TW'(HALF - 1));
  assign fall_evt = run && (tmr == TW'(PER - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tmr <= '0;
    else if (!run)     tmr <= '0;
    else if (fall_evt) tmr <= '0;
    else               tmr <= tmr + TW'(1);
  end

endmodule

// File: rtl/cftx_crc4.sv
module cftx_crc4
  import cftx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic seed_en,   // start a new frame with this bit
  input  logic step_en,   // fold one more payload bit
  input  logic shift_en,  // move the next check bit to the MSB
  input  logic din,
  output logic msb
);

  logic [CRC_W-1:0] rem;

  assign msb = rem[CRC_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rem <= '0;
    else if (seed_en)  rem <= crc_step('0, din);
    else if (step_en)  rem <= crc_step(rem, din);
    else if (shift_en) rem <= {rem[CRC_W-2:0], 1'b0};
  end

endmodule

// File: rtl/cmd_frame_tx.sv
module cmd_frame_tx
  import cftx_pkg::*;
#(
  parameter int HALF_PERIOD = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_kind,
  input  logic [1:0]  req_slave,
  input  logic [20:0] req_addr,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_wdata,
  output logic        link_clk,
  output logic        link_data,
  output logic        link_oe,
  output logic        tx_done
);

  localparam int CL_W = $clog2(CRC_W);

  tx_state_e          state;
  logic [FRAME_W-1:0] sreg;
  logic [CNT_W-1:0]   pay_left;
  logic [CL_W-1:0]    crc_left;
  logic               lclk_q, dout_q, oe_q, done_q;

  logic [FRAME_W-1:0] asm_frame;
  logic [CNT_W-1:0]   asm_nbits;
  logic               accept;
  logic               bit_rise, bit_fall;
  logic               crc_msb;
  logic               crc_step_en, crc_shift_en, crc_din;
  logic               pay_last, crc_last;

  assign accept   = req_valid && (state == ST_IDLE);
  assign pay_last = (pay_left == '0);
  assign crc_last = (crc_left == '0);

  cftx_frame_asm u_asm (
    .kind  (cmd_kind_e'(req_kind)),
    .slave (req_slave),
    .addr  (req_addr),
    .size  (req_size),
    .wdata (req_wdata),
    .frame (asm_frame),
    .nbits (asm_nbits)
  );

  cftx_phase_timer #(.HALF(HALF_PERIOD)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (state != ST_IDLE),
    .rise_evt (bit_rise),
    .fall_evt (bit_fall)
  );

  assign crc_din      = accept ? asm_frame[FRAME_W-1] : sreg[FRAME_W-1];
  assign crc_step_en  = (state == ST_PAY) && bit_fall && !pay_last;
  assign crc_shift_en = bit_fall &&
                        (((state == ST_PAY) && pay_last) ||
                         ((state == ST_CRC) && !crc_last));

  cftx_crc4 u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .seed_en  (accept),
    .step_en  (crc_step_en),
    .shift_en (crc_shift_en),
    .din      (crc_din),
    .msb      (crc_msb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sreg     <= '0;
      pay_left <= '0;
      crc_left <= '0;
      lclk_q   <= 1'b1;
      dout_q   <= 1'b1;
      oe_q     <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_PAY;
            sreg     <= asm_frame << 1;
            pay_left <= asm_nbits - CNT_W'(1);
            lclk_q   <= 1'b0;
            dout_q   <= ~asm_frame[FRAME_W-1];
            oe_q     <= 1'b1;
          end
        end
        ST_PAY: begin
          if (bit_rise) begin
            lclk_q <= 1'b1;
          end else if (bit_fall) begin
            lclk_q <= 1'b0;
            if (!pay_last) begin
              dout_q   <= ~sreg[FRAME_W-1];
              sreg     <= sreg << 1;
              pay_left <= pay_left - CNT_W'(1);
            end else begin
              state    <= ST_CRC;
              dout_q   <= ~crc_msb;
              crc_left <= CL_W'(CRC_W - 1);
            end
          end
        end
        ST_CRC: begin
          if (bit_rise) begin
            lclk_q <= 1'b1;
          end else if (bit_fall) begin
            if (!crc_last) begin
              lclk_q   <= 1'b0;
              dout_q   <= ~crc_msb;
              crc_left <= crc_left - CL_W'(1);
            end else begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
              oe_q   <= 1'b0;
              dout_q <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign link_clk  = lclk_q;
  assign link_data = dout_q;
  assign link_oe   = oe_q;
  assign tx_done   = done_q;

endmodule

// File: rtl/cmd_frame_tx_chk.sv
module cmd_frame_tx_chk #(
  parameter int HALF = 2
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic link_clk,
  input logic link_data,
  input logic link_oe,
  input logic tx_done,
  input logic bit_rise,
  input logic bit_fall
);

  logic [15:0] run_len;
  logic        clk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len  <= '0;
      clk_prev <= 1'b1;
    end else begin
      clk_prev <= link_clk;
      if (link_clk != clk_prev) run_len <= '0;
      else if (run_len != 16'hFFFF) run_len <= run_len + 16'd1;
    end
  end

  // R1
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!link_oe && link_clk));

  // R2
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (link_oe && !link_data && !link_clk));

  // R9
  a_r9_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bit_rise, bit_fall}));

  a_r9_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_clk) |-> (run_len == 16'(HALF - 1)));

  a_r9_high_width: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(link_clk) && $past(link_oe)) |-> (run_len == 16'(HALF - 1)));

  a_r9_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(link_data) && link_oe && $past(link_oe)) |-> $fell(link_clk));

  // R10
  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r10_ready_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> tx_done);

  // R11
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  a_r11_done_release: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (req_ready && !link_oe && link_clk));

endmodule

bind cmd_frame_tx cmd_frame_tx_chk #(.HALF(HALF_PERIOD)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .link_clk  (link_clk),
  .link_data (link_data),
  .link_oe   (link_oe),
  .tx_done   (tx_done),
  .bit_rise  (bit_rise),
  .bit_fall  (bit_fall)
);

// File: tb/tb_cmd_frame_tx.sv
module tb_cmd_frame_tx;

  localparam int HP = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = '0;
  logic [1:0]  req_slave = '0;
  logic [20:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        link_clk, link_data, link_oe, tx_done;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  cmd_frame_tx #(.HALF_PERIOD(HP)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_slave(req_slave), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata), .link_clk(link_clk),
    .link_data(link_data), .link_oe(link_oe), .tx_done(tx_done)
  );

  // wire capture at each rising link clock, logical value
  bit cap [0:16383];
  int cap_n = 0;
  always @(posedge link_clk) begin
    if (link_oe && cap_n < 16384) begin
      cap[cap_n] = ~link_data;
      cap_n = cap_n + 1;
    end
  end

  bit exp_q [$];

  task automatic check(input bit ok, input string req, input longint act,
                       input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push(input longint val, input int w);
    for (int i = w - 1; i >= 0; i--) exp_q.push_back(bit'((val >> i) & 1));
  endtask

  // expected frame: start, body, then remainder by long division
  task automatic build(input int kind, input int slv, input int addr,
                       input int sz, input longint wd);
    bit div [$];
    int nb;
    int a;
    exp_q.delete();
    push(1, 1);
    push(slv, 2);
    if (kind <= 1) begin
      nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
      a = addr;
      if (nb == 2) a = a & ~1;
      if (nb == 4) a = (a & ~3) | 1;
      push(4, 3);                 // R3 opcode 100
      push(kind == 0 ? 1 : 0, 1); // R3 direction
      push(a, 21);                // R4 folded address
      push(nb > 1 ? 1 : 0, 1);    // R4 size bit
      if (kind == 1)
        for (int b = 0; b < nb; b++) push((wd >> (8 * b)) & 8'hFF, 8); // R5
    end else if (kind == 2) begin
      push(2, 3);                 // R6
    end else begin
      push(63, 6);                // R7
    end
    div = exp_q;
    for (int k = 0; k < 4; k++) div.push_back(1'b0);
    for (int i = 0; i < exp_q.size(); i++) begin
      if (div[i]) begin
        div[i]   = div[i]   ^ 1'b1;
        div[i+3] = div[i+3] ^ 1'b1;
        div[i+4] = div[i+4] ^ 1'b1;
      end
    end
    for (int k = 0; k < 4; k++) exp_q.push_back(div[exp_q.size() - 0 + 0 - exp_q.size() + div.size() - 4 + k]); // R8
  endtask

  task automatic send(input int kind, input int slv, input int addr,
                      input int sz, input longint wd, input bit disturb,
                      input string tag);
    int base, c, mism, firstbad;
    build(kind, slv, addr, sz, wd);
    @(negedge clk);
    req_kind  = 2'(kind);
    req_slave = 2'(slv);
    req_addr  = 21'(addr);
    req_size  = 2'(sz);
    req_wdata = 32'(wd);
    req_valid = 1'b1;
    base = cap_n;
    @(posedge clk);
    @(negedge clk);
    if (disturb) begin
      check(req_ready == 1'b0, "R10 ready low after accept", req_ready, 0);
      req_kind  = ~req_kind;
      req_slave = ~req_slave;
      req_addr  = ~req_addr;
      req_size  = ~req_size;
      req_wdata = ~req_wdata;
    end else begin
      req_valid = 1'b0;
    end
    c = 0;
    while (c < 4000) begin
      @(posedge clk);
      c++;
      @(negedge clk);
      if (c == 5) req_valid = 1'b0;
      if (tx_done) break;
    end
    check(c == exp_q.size() * 2 * HP, {"R9 frame length cycles ", tag}, c,
          exp_q.size() * 2 * HP);
    check(req_ready && !link_oe && link_clk && link_data,
          {"R11 release at done ", tag},
          {req_ready, link_oe, link_clk, link_data}, 4'b1011);
    check(cap_n - base == exp_q.size(), {"R2 bit count ", tag}, cap_n - base,
          exp_q.size());
    mism = 0;
    firstbad = -1;
    for (int i = 0; i < exp_q.size(); i++) begin
      if (base + i >= cap_n || cap[base+i] != exp_q[i]) begin
        mism++;
        if (firstbad < 0) firstbad = i;
      end
    end
    check(mism == 0, {"R3 R5 R6 R7 R8 bits ", tag, disturb ? " R10 ignored" : ""},
          firstbad, -1);
    check(cap[base] == 1'b1, {"R2 start bit ", tag}, cap[base], 1);
    @(negedge clk);
    check(!tx_done, {"R11 done one cycle ", tag}, tx_done, 0);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !link_oe && link_clk && link_data && !tx_done,
          "R1 reset state", {req_ready, link_oe, link_clk, link_data, tx_done},
          5'b10110);

    for (int k = 0; k < 2; k++)
      for (int s = 0; s < 4; s++)
        for (int sl = 0; sl < 4; sl++)
          for (int ap = 0; ap < 2; ap++) begin
            int ad;
            longint wd;
            ad = (ap == 0) ? (21'h1A5A5B ^ (sl << 7)) : (21'h000002 | (s << 12));
            wd = 32'h8C3E_15A7 ^ (sl * 32'h0101_0101) ^ (s << 20);
            send(k, sl, ad, s, wd, 1'b0, k == 0 ? "R4 read" : "R4 R5 write");
          end

    for (int sl = 0; sl < 4; sl++) send(2, sl, 0, 0, 0, 1'b0, "R6 poll");
    for (int sl = 0; sl < 4; sl++) send(3, sl, 0, 0, 0, 1'b0, "R7 term");

    send(1, 2, 21'h0ABCDE, 2, 32'hF00D_B33F, 1'b1, "R10 write busy");
    send(3, 1, 0, 0, 0, 1'b1, "R10 term busy");
    @(negedge clk);
    check(req_ready && !link_oe, "R1 idle after frames", {req_ready, link_oe}, 2'b10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule